// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits beside a four-bank single-data-rate SDRAM interface. On every rising clock edge it samples the row strobe, column strobe and write enable (all active low), the two bank-select bits and the address bus. It turns each sample into a command and keeps, for each bank, whether the bank is open and which row it holds. It also keeps three timers per bank: a close-to-reopen (row precharge) guard, an open-time limit, and a countdown for a pending auto-precharge.

Illegal sequences are reported as one-cycle error pulses and leave the bank state unchanged. The three cases are: an activate that comes too early or hits an open bank, a column access to a closed bank, and a mode-register write while any bank is open. Burst length and CAS latency are static configuration inputs. The block holds no data path and no memory array.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: Activate (ras_n=0, cas_n=1, we_n=1) to a legal bank `ba` sets `bank_open[ba]` and loads `addr` into `bank_row[ba*ROW_W +: ROW_W]`. Both are visible in the cycle after the sampling edge. Other banks are unaffected.
- R2: Precharge (ras_n=0, cas_n=1, we_n=0) with addr[10]=0 closes only bank `ba`, from the cycle after the edge.
- R3: Precharge with addr[10]=1 closes all four banks whatever `ba` holds.
- R4: A bank closed at edge k accepts an activate no earlier than edge k+T_RP. An earlier activate, or an activate to an open bank, raises `err_act` for one cycle and changes no state.
- R5: `tras_timeout[b]` is high while bank b is open and at least T_RAS_MAX edges have passed since its activate edge.
- R6: A column command is ras_n=1, cas_n=0. we_n=0 means write, we_n=1 means read, and addr[10]=1 requests auto-precharge. A column command to a closed bank, or to a bank with an auto-precharge pending, raises `err_col` for one cycle and changes no state.
- R7: Burst length is 1<<bl_sel (bl_sel 0..3 gives 1, 2, 4 or 8). A write with auto-precharge at edge k writes its beats at edges k..k+BL-1, and the bank closes at edge k+BL whatever the CAS latency.
- R8: CAS latency is 3 when cl3=1 and 2 when cl3=0. A read with auto-precharge at edge k outputs its last beat at edge k+CL+BL-1. The bank closes CL-1 edges before that beat (two for CL 3, one for CL 2), which is edge k+BL. The closing edge starts the R4 guard.
- R9: Extended mode register set (ras_n, cas_n and we_n all 0) raises `err_emrs` for one cycle if any bank is open. It never changes bank state.
- R10: After reset all banks are idle, all flags are low and all timers are expired, so an activate on the first edge after reset is legal.
- R11: NOP (all high), refresh (ras_n=0, cas_n=0, we_n=1) and burst stop (ras_n=1, cas_n=1, we_n=0) change no bank state and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | ROW_W | Address bus; bit 10 selects all-bank or auto-precharge |
| bl_sel | input | 2 | Burst length code, BL = 1<<bl_sel |
| cl3 | input | 1 | 1: CAS latency 3, 0: CAS latency 2 |
| bank_open | output | 4 | Per-bank open flag |
| bank_row | output | 4*ROW_W | Latched row per bank, bank b at b*ROW_W |
| tras_timeout | output | 4 | Per-bank open-time limit reached |
| err_act | output | 1 | Rejected activate pulse |
| err_col | output | 1 | Rejected column command pulse |
| err_emrs | output | 1 | Mode-register write with an open bank pulse |

## Verification
The bench tries an activate one edge before the precharge guard expires and again exactly on it. A guard that is off by one either accepts the early activate or rejects the legal one. Auto-precharge closes are timed for a BL 4 write, a BL 2 read at CL 2 and a BL 8 read at CL 3. A close point that adds the CAS latency shows up as a bank staying open too long, and a column command sent during the pending window must be rejected. The open-time flag is sampled one edge before and at the limit, and precharge-all is sent with a non-zero bank field to catch a decoder that honours `ba` for that command.

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker #(
  parameter int ROW_W     = 13,
  parameter int T_RP      = 3,
  parameter int T_RAS_MAX = 8192
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic [1:0]         ba,
  input  logic [ROW_W-1:0]   addr,
  input  logic [1:0]         bl_sel,
  input  logic               cl3,
  output logic [3:0]         bank_open,
  output logic [4*ROW_W-1:0] bank_row,
  output logic [3:0]         tras_timeout,
  output logic               err_act,
  output logic               err_col,
  output logic               err_emrs
);
  localparam int RPW = $clog2(T_RP + 1);
  localparam int RSW = $clog2(T_RAS_MAX + 1);

  logic [RPW-1:0] trp_q [4];
  logic [RSW-1:0] ras_q [4];
  logic [3:0]     ap_q  [4];
  logic [3:0]     close_v;

  wire a10     = addr[10];
  wire is_act  = !ras_n &  cas_n &  we_n;
  wire is_pre  = !ras_n &  cas_n & !we_n;
  wire is_col  =  ras_n & !cas_n;
  wire is_emrs = !ras_n & !cas_n & !we_n;

  wire [3:0] sel = 4'b0001 << ba;
  wire [3:0] bl  = 4'd1 << bl_sel;
  wire [3:0] cl  = cl3 ? 4'd3 : 4'd2;
  // read: last beat at CL+BL-1, internal close CL-1 cycles before it
  wire [3:0] ap_load = we_n ? (cl + bl - 4'd1 - (cl3 ? 4'd2 : 4'd1)) : bl;

  wire act_ok = !bank_open[ba] && (trp_q[ba] == '0);
  wire col_ok =  bank_open[ba] && (ap_q[ba] == 4'd0);

  always_comb
    for (int b = 0; b < 4; b++) begin
      close_v[b]      = (ap_q[b] == 4'd1) || (is_pre && (a10 || sel[b]));
      tras_timeout[b] = bank_open[b] && (ras_q[b] == RSW'(T_RAS_MAX));
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_open <= '0;
      bank_row  <= '0;
      err_act   <= 1'b0;
      err_col   <= 1'b0;
      err_emrs  <= 1'b0;
      for (int b = 0; b < 4; b++) begin
        trp_q[b] <= '0;
        ras_q[b] <= '0;
        ap_q[b]  <= 4'd0;
      end
    end else begin
      err_act  <= is_act && !act_ok;
      err_col  <= is_col && !col_ok;
      err_emrs <= is_emrs && (bank_open != 4'd0);
      for (int b = 0; b < 4; b++) begin
        if (close_v[b] && bank_open[b])
          trp_q[b] <= RPW'(T_RP - 1);
        else if (trp_q[b] != '0)
          trp_q[b] <= trp_q[b] - 1'b1;

        if (close_v[b])
          ap_q[b] <= 4'd0;
        else if (ap_q[b] != 4'd0)
          ap_q[b] <= ap_q[b] - 4'd1;
        else if (is_col && col_ok && a10 && sel[b])
          ap_q[b] <= ap_load;

        if (close_v[b]) begin
          bank_open[b] <= 1'b0;
        end else if (is_act && act_ok && sel[b]) begin
          bank_open[b]                  <= 1'b1;
          bank_row[b*ROW_W +: ROW_W]    <= addr;
          ras_q[b]                      <= '0;
        end else if (bank_open[b] && (ras_q[b] < RSW'(T_RAS_MAX))) begin
          ras_q[b] <= ras_q[b] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdr_cmd_tracker_chk.sv
module sdr_cmd_tracker_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [ROW_W-1:0] addr,
  input logic [3:0]       bank_open,
  input logic [3:0]       tras_timeout,
  input logic             err_act,
  input logic             err_col,
  input logic             err_emrs
);
  wire act_c  = !ras_n &  cas_n &  we_n;
  wire col_c  =  ras_n & !cas_n;
  wire pall_c = !ras_n &  cas_n & !we_n & addr[10];

  p_open_by_act_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !act_c |=> ((bank_open & ~$past(bank_open)) == 4'd0));

  p_pall_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pall_c |=> (bank_open == 4'd0));

  p_act_err_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !act_c |=> !err_act);

  p_tras_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tras_timeout & ~bank_open) == 4'd0);

  p_col_err_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !col_c |=> !err_col);

  p_emrs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_emrs |-> ($past(bank_open) != 4'd0));
endmodule

bind sdr_cmd_tracker sdr_cmd_tracker_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/sim_sdr_cmd_tracker.sv
module sim_sdr_cmd_tracker;
  localparam int RW = 13;
  localparam int TRP = 4;
  localparam int TRAS = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0, bl_sel = 2'd2;
  logic [RW-1:0] addr = '0;
  logic cl3 = 1'b0;
  logic [3:0] bank_open, tras_timeout;
  logic [4*RW-1:0] bank_row;
  logic err_act, err_col, err_emrs;

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_open [4];
  logic [RW-1:0] m_row [4];
  int m_sc [4], m_sa [4], m_ap [4];
  bit e_act, e_col, e_emrs;

  sdr_cmd_tracker #(.ROW_W(RW), .T_RP(TRP), .T_RAS_MAX(TRAS)) u0 (
    .clk, .rst_n, .ras_n, .cas_n, .we_n, .ba, .addr, .bl_sel, .cl3,
    .bank_open, .bank_row, .tras_timeout, .err_act, .err_col, .err_emrs);

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_open();
    for (int b = 0; b < 4; b++) exp_open[b] = m_open[b];
  endfunction

  function automatic logic [3:0] exp_tmo();
    for (int b = 0; b < 4; b++) exp_tmo[b] = m_open[b] && (m_sa[b] >= TRAS);
  endfunction

  task automatic compare_all();
    chk("R1 bank_open", 64'(bank_open), 64'(exp_open()));
    for (int b = 0; b < 4; b++) chk("R1 bank_row", 64'(bank_row[b*RW +: RW]), 64'(m_row[b]));
    chk("R4 err_act", 64'(err_act), 64'(e_act));
    chk("R6 err_col", 64'(err_col), 64'(e_col));
    chk("R9 err_emrs", 64'(err_emrs), 64'(e_emrs));
    chk("R5 tras_timeout", 64'(tras_timeout), 64'(exp_tmo()));
  endtask

  task automatic model_step();
    bit act, pre, col, emrs, any;
    int bb, blen, cl, n_ap;
    act = !ras_n && cas_n && we_n;
    pre = !ras_n && cas_n && !we_n;
    col = ras_n && !cas_n;
    emrs = !ras_n && !cas_n && !we_n;
    bb = int'(ba);
    blen = 1 << bl_sel;
    cl = cl3 ? 3 : 2;
    any = m_open[0] || m_open[1] || m_open[2] || m_open[3];
    e_act = act && (m_open[bb] || (m_sc[bb] + 1 < TRP));
    e_col = col && (!m_open[bb] || m_ap[bb] != 0);
    e_emrs = emrs && any;
    for (int b = 0; b < 4; b++) begin
      bit was_open;
      int was_ap;
      was_open = m_open[b];
      was_ap = m_ap[b];
      m_sc[b] = (m_sc[b] < 1000) ? m_sc[b] + 1 : 1000;
      m_sa[b] = (m_sa[b] < 1000) ? m_sa[b] + 1 : 1000;
      if (was_ap > 1) m_ap[b] = was_ap - 1;
      if (was_ap == 1 || (pre && (addr[10] || bb == b) && was_open)) begin
        m_open[b] = 0; m_sc[b] = 0; m_ap[b] = 0;
      end
    end
    if (act && !e_act) begin
      m_open[bb] = 1; m_row[bb] = addr; m_sa[bb] = 0;
    end
    if (col && !e_col && addr[10]) begin
      n_ap = we_n ? (cl + blen - 1) - (cl - 1) : blen;
      m_ap[bb] = n_ap;
    end
  endtask

  task automatic do_cmd(logic r, logic c, logic w, logic [1:0] b, logic [RW-1:0] a);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; ba = b; addr = a;
    model_step();
    @(posedge clk);
    #2;
    compare_all();
  endtask

  task automatic nop();                   do_cmd(1, 1, 1, 2'd0, '0); endtask
  task automatic act(int b, int row);     do_cmd(0, 1, 1, 2'(b), RW'(row)); endtask
  task automatic pre(int b);              do_cmd(0, 1, 0, 2'(b), '0); endtask
  task automatic pall(int b);             do_cmd(0, 1, 0, 2'(b), RW'(1 << 10)); endtask
  task automatic colc(bit wr, int b, bit ap); do_cmd(1, 0, !wr, 2'(b), RW'(ap) << 10); endtask
  task automatic emrs();                  do_cmd(0, 0, 0, 2'd0, RW'(32'h1a5)); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < 4; b++) begin
      m_open[b] = 0; m_row[b] = '0; m_sc[b] = 1000; m_sa[b] = 0; m_ap[b] = 0;
    end
    e_act = 0; e_col = 0; e_emrs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R10 reset bank_open", 64'(bank_open), 64'h0);
    chk("R10 reset flags", 64'({err_act, err_col, err_emrs, tras_timeout}), 64'h0);

    act(0, 'h123);
    chk("R10 activate right after reset", 64'({bank_open[0], err_act}), 64'h2);
    chk("R1 row latch", 64'(bank_row[0 +: RW]), 64'h123);
    act(1, 'h0ab);
    pre(1);
    chk("R2 single precharge", 64'(bank_open), 64'h1);
    act(2, 'h777);
    act(3, 'h1ff);
    pall(1);
    chk("R3 precharge all", 64'(bank_open), 64'h0);

    act(0, 'h55);
    chk("R4 early activate flagged", 64'({err_act, bank_open[0]}), 64'h2);
    nop();
    act(0, 'h55);
    chk("R4 activate at T_RP-1 flagged", 64'({err_act, bank_open[0]}), 64'h2);
    act(0, 'h55);
    chk("R4 activate at T_RP legal", 64'({err_act, bank_open[0]}), 64'h1);
    act(0, 'h66);
    chk("R4 activate to open bank", 64'({err_act, bank_row[0 +: RW]}), 64'({1'b1, 13'h55}));

    pre(0);
    repeat (TRP - 1) nop();
    act(0, 'h99);
    repeat (TRAS - 1) nop();
    chk("R5 before limit", 64'(tras_timeout[0]), 64'h0);
    nop();
    chk("R5 at limit", 64'(tras_timeout[0]), 64'h1);

    colc(0, 2, 0);
    chk("R6 read to idle bank", 64'({err_col, bank_open}), 64'h11);
    colc(1, 0, 0);
    chk("R6 write to open bank", 64'({err_col, bank_open}), 64'h01);

    bl_sel = 2'd2; cl3 = 1'b1;
    colc(1, 0, 1);
    colc(0, 0, 0);
    chk("R6 column during pending auto-precharge", 64'({err_col, bank_open[0]}), 64'h3);
    nop(); nop();
    chk("R7 write AP open before k+BL", 64'(bank_open[0]), 64'h1);
    nop();
    chk("R7 write AP closes at k+BL", 64'(bank_open[0]), 64'h0);

    bl_sel = 2'd1; cl3 = 1'b0;
    act(1, 'h321);
    colc(0, 1, 1);
    nop();
    chk("R8 CL2 BL2 open before close", 64'(bank_open[1]), 64'h1);
    nop();
    chk("R8 CL2 BL2 closed", 64'(bank_open[1]), 64'h0);

    bl_sel = 2'd3; cl3 = 1'b1;
    act(2, 'h222);
    colc(0, 2, 1);
    repeat (7) nop();
    chk("R8 CL3 BL8 open before close", 64'(bank_open[2]), 64'h1);
    nop();
    chk("R8 CL3 BL8 closed", 64'(bank_open[2]), 64'h0);
    act(2, 'h222);
    chk("R8 auto close starts tRP", 64'({err_act, bank_open[2]}), 64'h2);

    act(3, 'h333);
    emrs();
    chk("R9 emrs with open bank", 64'({err_emrs, bank_open}), 64'h18);
    pall(0);
    emrs();
    chk("R9 emrs all idle", 64'({err_emrs, bank_open}), 64'h00);

    repeat (TRP) nop();
    act(3, 'h444);
    do_cmd(0, 0, 1, 2'd3, '0);
    do_cmd(1, 1, 0, 2'd3, RW'(1 << 10));
    nop();
    chk("R11 refresh/burst stop/nop no effect", 64'({err_act, err_col, err_emrs, bank_open}), 64'h08);

    for (int i = 0; i < 4000; i++) begin
      int r;
      if (i % 97 == 0) begin bl_sel = 2'($urandom_range(0, 3)); cl3 = 1'($urandom_range(0, 1)); end
      r = $urandom_range(0, 99);
      if (r < 30)      act($urandom_range(0, 3), $urandom_range(0, 8191));
      else if (r < 42) pre($urandom_range(0, 3));
      else if (r < 46) pall($urandom_range(0, 3));
      else if (r < 76) colc(1'($urandom_range(0, 1)), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
      else if (r < 80) emrs();
      else             nop();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule